// File: doc/BRIEF.md
# Merging Miss Tracking Table

This block keeps track of cache-line misses that are still waiting on the next memory level, on behalf of a load/store unit that serves many threads. A thread request arrives as an address and a thread number. The address splits into a block address, which is every bit above the byte offset, and a byte offset inside the block. A content-addressable lookup compares the block address against every live entry. If an entry for that block is already live, the request is appended to that entry's merge list. If none is, the lowest-numbered free entry is claimed, and a fill request carrying the block address and the entry number goes out.

Fill responses come back tagged with an entry number, in any order. Accepting a response frees the entry straight away. A small sequencer then plays back one completion per merged thread, in the order the threads were merged. Each completion carries the thread number, the byte offset and the data word that holds that offset. When the matching entry's merge list is full, or when a new block finds no free entry, the request port stalls until space opens up. The defaults are 128 entries, 8 merge slots per entry and 128-byte blocks.

Top module: `miss_merge_table`

## Requirements
- R1: The block address is `req_addr` with its low log2(BLK_BYTES) bits removed (7 bits at the default), and the offset is those low bits. At no time do two live entries hold the same block address.
- R2: A request whose block matches a live entry with fewer than SLOTS merged threads is accepted in the same cycle. It is appended to that entry, and no fill request follows.
- R3: A request for a block with no live entry claims the lowest-numbered free entry. One cycle after acceptance, `fill_req_valid` pulses high for one cycle with `fill_req_blk` equal to the block address and `fill_req_id` equal to that entry.
- R4: `req_ready` is low when the matching entry already holds SLOTS threads, or when there is no match and every entry is live. A request that is not accepted changes nothing and produces no fill request.
- R5: After a response for a live entry is accepted, one completion per merged thread appears on consecutive cycles. The first appears in the cycle after acceptance, and they come in merge order. Each carries the thread's `cpl_tid` and `cpl_off`, plus `cpl_word` = `rsp_data[k*WORD_W +: WORD_W]` with k = offset / (WORD_W/8).
- R6: Responses may name live entries in any order. Each one delivers only the threads merged into the entry it names.
- R7: Accepting a response frees its entry in that same cycle, so a later request for the same block claims a fresh entry. `rsp_ready` is low while completions are still being played back.
- R8: A response naming an entry that is not live produces no completion and no change to the table. It sets `err_flag`, which stays high until reset.
- R9: After reset there are no live entries: `req_ready` and `rsp_ready` are high, and `fill_req_valid`, `cpl_valid` and `err_flag` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A thread request is presented |
| req_ready | output | 1 | The request is accepted this cycle |
| req_addr | input | ADDR_W | Byte address of the request |
| req_tid | input | TID_W | Thread number of the request |
| fill_req_valid | output | 1 | Fill request to the next level, one cycle |
| fill_req_blk | output | ADDR_W-log2(BLK_BYTES) | Block address to fetch |
| fill_req_id | output | log2(ENTRIES) | Entry that waits for this block |
| rsp_valid | input | 1 | A fill response is presented |
| rsp_ready | output | 1 | The response is accepted this cycle |
| rsp_id | input | log2(ENTRIES) | Entry the response belongs to |
| rsp_data | input | BLK_BYTES*8 | Whole block of data |
| cpl_valid | output | 1 | A completion is presented |
| cpl_tid | output | TID_W | Thread being completed |
| cpl_off | output | log2(BLK_BYTES) | Byte offset recorded for that thread |
| cpl_word | output | WORD_W | Data word containing that offset |
| err_flag | output | 1 | Sticky: a response named an entry that was not live |

## Verification
`req_ready` depends only on inputs and the current table, so the bench drives each request half a cycle before the edge and compares the stall decision before that edge. Fill requests are registered, so they are due exactly one edge after acceptance and are sampled at the next falling edge. Completions begin one edge after a response is accepted and then advance one per edge. The bench reads one completion per falling edge, checks that `rsp_ready` stays low during the playback, and checks that `cpl_valid` drops right after the last merged thread. A reference table in the bench, built from the requirements, supplies the expected entry numbers and stall decisions for a small four-entry, two-slot configuration.

// File: rtl/mmt_pkg.sv
package mmt_pkg;
   typedef enum logic {
      PLAY_IDLE = 1'b0,
      PLAY_RUN  = 1'b1
   } play_st_e;
endpackage

// File: rtl/mmt_cam.sv
module mmt_cam #(
   parameter int ENTRIES = 128,
   parameter int TAG_W   = 25,
   localparam int ID_W   = $clog2(ENTRIES)
) (
   input  logic [ENTRIES-1:0] live_look,
   input  logic [ENTRIES-1:0] live_now,
   input  logic [TAG_W-1:0]   tags [ENTRIES],
   input  logic [TAG_W-1:0]   look_tag,
   output logic [ENTRIES-1:0] match_vec,
   output logic               hit,
   output logic [ID_W-1:0]    hit_idx,
   output logic               any_free,
   output logic [ID_W-1:0]    free_idx
);
   for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
      assign match_vec[g] = live_look[g] && (tags[g] == look_tag);
   end

   always_comb begin
      hit      = 1'b0;
      hit_idx  = '0;
      any_free = 1'b0;
      free_idx = '0;
      for (int i = ENTRIES - 1; i >= 0; i--) begin
         if (match_vec[i]) begin
            hit     = 1'b1;
            hit_idx = ID_W'(i);
         end
         if (!live_now[i]) begin
            any_free = 1'b1;
            free_idx = ID_W'(i);
         end
      end
   end
endmodule

// File: rtl/mmt_drain.sv
module mmt_drain
   import mmt_pkg::*;
#(
   parameter int SLOTS    = 8,
   parameter int TID_W    = 10,
   parameter int OFF_W    = 7,
   parameter int BLK_BITS = 1024,
   parameter int WORD_W   = 32,
   localparam int CNT_W   = $clog2(SLOTS + 1),
   localparam int SIDX_W  = $clog2(SLOTS)
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          start,
   input  logic [CNT_W-1:0]              cnt_in,
   input  logic [SLOTS-1:0][TID_W-1:0]   tid_in,
   input  logic [SLOTS-1:0][OFF_W-1:0]   off_in,
   input  logic [BLK_BITS-1:0]           data_in,
   output logic                          busy,
   output logic                          cpl_valid,
   output logic [TID_W-1:0]              cpl_tid,
   output logic [OFF_W-1:0]              cpl_off,
   output logic [WORD_W-1:0]             cpl_word
);
   localparam int NWORDS = BLK_BITS / WORD_W;
   localparam int WB     = $clog2(WORD_W / 8);

   play_st_e                    st;
   logic [SIDX_W-1:0]           idx;
   logic [CNT_W-1:0]            cnt_q;
   logic [SLOTS-1:0][TID_W-1:0] tid_q;
   logic [SLOTS-1:0][OFF_W-1:0] off_q;
   logic [BLK_BITS-1:0]         data_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st  <= PLAY_IDLE;
         idx <= '0;
      end else if (st == PLAY_IDLE) begin
         if (start && cnt_in != '0) st <= PLAY_RUN;
         idx <= '0;
      end else if (CNT_W'(idx) == cnt_q - CNT_W'(1)) begin
         st  <= PLAY_IDLE;
         idx <= '0;
      end else begin
         idx <= idx + SIDX_W'(1);
      end
   end

   always_ff @(posedge clk) begin
      if (start) begin
         cnt_q  <= cnt_in;
         tid_q  <= tid_in;
         off_q  <= off_in;
         data_q <= data_in;
      end
   end

   assign busy      = (st == PLAY_RUN);
   assign cpl_valid = busy;
   assign cpl_tid   = tid_q[idx];
   assign cpl_off   = off_q[idx];

   if (NWORDS > 1) begin : g_sel
      logic [OFF_W-WB-1:0] wsel;
      assign wsel     = cpl_off[OFF_W-1:WB];
      assign cpl_word = data_q[wsel*WORD_W +: WORD_W];
   end else begin : g_whole
      assign cpl_word = data_q;
   end

   AST_DRAIN_IDX: assert property (@(posedge clk) disable iff (!rst_n)
      cpl_valid |-> (CNT_W'(idx) < cnt_q)); // R5
   AST_DRAIN_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !start); // R7
endmodule

// File: rtl/miss_merge_table.sv
module miss_merge_table #(
   parameter int ENTRIES   = 128,
   parameter int SLOTS     = 8,
   parameter int ADDR_W    = 32,
   parameter int TID_W     = 10,
   parameter int BLK_BYTES = 128,
   parameter int WORD_W    = 32,
   localparam int OFF_W    = $clog2(BLK_BYTES),
   localparam int TAG_W    = ADDR_W - OFF_W,
   localparam int ID_W     = $clog2(ENTRIES),
   localparam int BLK_BITS = BLK_BYTES * 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                req_valid,
   output logic                req_ready,
   input  logic [ADDR_W-1:0]   req_addr,
   input  logic [TID_W-1:0]    req_tid,
   output logic                fill_req_valid,
   output logic [TAG_W-1:0]    fill_req_blk,
   output logic [ID_W-1:0]     fill_req_id,
   input  logic                rsp_valid,
   output logic                rsp_ready,
   input  logic [ID_W-1:0]     rsp_id,
   input  logic [BLK_BITS-1:0] rsp_data,
   output logic                cpl_valid,
   output logic [TID_W-1:0]    cpl_tid,
   output logic [OFF_W-1:0]    cpl_off,
   output logic [WORD_W-1:0]   cpl_word,
   output logic                err_flag
);
   localparam int CNT_W  = $clog2(SLOTS + 1);
   localparam int SIDX_W = $clog2(SLOTS);

   if (ENTRIES < 2 || (ENTRIES & (ENTRIES - 1)) != 0) begin : g_bad_entries
      $error("ENTRIES must be a power of two of at least 2");
   end
   if (SLOTS < 2) begin : g_bad_slots
      $error("SLOTS must be at least 2");
   end
   if ((BLK_BYTES & (BLK_BYTES - 1)) != 0 || ADDR_W <= OFF_W) begin : g_bad_blk
      $error("BLK_BYTES must be a power of two below the address range");
   end
   if (WORD_W % 8 != 0 || ((WORD_W / 8) & (WORD_W / 8 - 1)) != 0 || BLK_BITS % WORD_W != 0) begin : g_bad_word
      $error("WORD_W must be a power-of-two byte count dividing the block");
   end

   logic [ENTRIES-1:0]              live;
   logic [ENTRIES-1:0]              live_look;
   logic [TAG_W-1:0]                tag   [ENTRIES];
   logic [CNT_W-1:0]                cnt   [ENTRIES];
   logic [SLOTS-1:0][TID_W-1:0]     s_tid [ENTRIES];
   logic [SLOTS-1:0][OFF_W-1:0]     s_off [ENTRIES];

   logic [TAG_W-1:0] req_tag;
   logic [OFF_W-1:0] req_off;
   logic [ENTRIES-1:0] match_vec;
   logic             hit, any_free, hit_full;
   logic [ID_W-1:0]  hit_idx, free_idx;
   logic [CNT_W-1:0] hit_cnt;
   logic             busy, rsp_fire, play_start, do_merge, do_alloc;

   assign req_tag    = req_addr[ADDR_W-1:OFF_W];
   assign req_off    = req_addr[OFF_W-1:0];
   assign rsp_ready  = !busy;
   assign rsp_fire   = rsp_valid && rsp_ready;
   assign play_start = rsp_fire && live[rsp_id];

   for (genvar g = 0; g < ENTRIES; g++) begin : g_look
      assign live_look[g] = live[g] && !(play_start && rsp_id == ID_W'(g));
   end

   mmt_cam #(.ENTRIES(ENTRIES), .TAG_W(TAG_W)) u_cam (
      .live_look(live_look), .live_now(live), .tags(tag), .look_tag(req_tag),
      .match_vec(match_vec), .hit(hit), .hit_idx(hit_idx),
      .any_free(any_free), .free_idx(free_idx)
   );

   assign hit_cnt   = cnt[hit_idx];
   assign hit_full  = (hit_cnt == CNT_W'(SLOTS));
   assign req_ready = hit ? !hit_full : any_free;
   assign do_merge  = req_valid && req_ready && hit;
   assign do_alloc  = req_valid && req_ready && !hit;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         live           <= '0;
         err_flag       <= 1'b0;
         fill_req_valid <= 1'b0;
         fill_req_blk   <= '0;
         fill_req_id    <= '0;
         for (int i = 0; i < ENTRIES; i++) cnt[i] <= '0;
      end else begin
         if (play_start) live[rsp_id] <= 1'b0;
         if (rsp_fire && !live[rsp_id]) err_flag <= 1'b1;
         if (do_alloc) begin
            live[free_idx] <= 1'b1;
            cnt[free_idx]  <= CNT_W'(1);
         end
         if (do_merge) cnt[hit_idx] <= hit_cnt + CNT_W'(1);
         fill_req_valid <= do_alloc;
         if (do_alloc) begin
            fill_req_blk <= req_tag;
            fill_req_id  <= free_idx;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (do_alloc) begin
         tag[free_idx]      <= req_tag;
         s_tid[free_idx][0] <= req_tid;
         s_off[free_idx][0] <= req_off;
      end
      if (do_merge) begin
         s_tid[hit_idx][hit_cnt[SIDX_W-1:0]] <= req_tid;
         s_off[hit_idx][hit_cnt[SIDX_W-1:0]] <= req_off;
      end
   end

   mmt_drain #(
      .SLOTS(SLOTS), .TID_W(TID_W), .OFF_W(OFF_W),
      .BLK_BITS(BLK_BITS), .WORD_W(WORD_W)
   ) u_drain (
      .clk(clk), .rst_n(rst_n), .start(play_start),
      .cnt_in(cnt[rsp_id]), .tid_in(s_tid[rsp_id]), .off_in(s_off[rsp_id]),
      .data_in(rsp_data), .busy(busy), .cpl_valid(cpl_valid),
      .cpl_tid(cpl_tid), .cpl_off(cpl_off), .cpl_word(cpl_word)
   );

   AST_UNIQUE_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(match_vec)); // R1
   AST_NO_FILL_ON_MERGE: assert property (@(posedge clk) disable iff (!rst_n)
      do_merge |=> !fill_req_valid); // R2
   AST_FILL_MATCHES_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
      fill_req_valid |-> (live[fill_req_id] && tag[fill_req_id] == fill_req_blk)); // R3
   AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      err_flag |=> err_flag); // R8

   for (genvar g = 0; g < ENTRIES; g++) begin : g_cnt_chk
      AST_CNT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
         live[g] |-> (cnt[g] != '0 && cnt[g] <= CNT_W'(SLOTS))); // R2
   end
endmodule

// File: tb/miss_merge_table_test.sv
module miss_merge_table_test;
   localparam int NE = 4;
   localparam int NS = 2;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         req_valid = 1'b0;
   logic         req_ready;
   logic [11:0]  req_addr = '0;
   logic [3:0]   req_tid = '0;
   logic         fill_req_valid;
   logic [7:0]   fill_req_blk;
   logic [1:0]   fill_req_id;
   logic         rsp_valid = 1'b0;
   logic         rsp_ready;
   logic [1:0]   rsp_id = '0;
   logic [127:0] rsp_data = '0;
   logic         cpl_valid;
   logic [3:0]   cpl_tid;
   logic [3:0]   cpl_off;
   logic [31:0]  cpl_word;
   logic         err_flag;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   int mvld [NE];
   int mblk [NE];
   int mcnt [NE];
   int mtid [NE][NS];
   int moff [NE][NS];

   always #5 clk = ~clk;

   miss_merge_table #(
      .ENTRIES(NE), .SLOTS(NS), .ADDR_W(12), .TID_W(4),
      .BLK_BYTES(16), .WORD_W(32)
   ) uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_addr(req_addr), .req_tid(req_tid), .fill_req_valid(fill_req_valid),
      .fill_req_blk(fill_req_blk), .fill_req_id(fill_req_id),
      .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_id(rsp_id),
      .rsp_data(rsp_data), .cpl_valid(cpl_valid), .cpl_tid(cpl_tid),
      .cpl_off(cpl_off), .cpl_word(cpl_word), .err_flag(err_flag)
   );

   task automatic chk(input bit ok, input string rq, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
      end
   endtask

   function automatic logic [127:0] mk(input int seed);
      logic [127:0] d;
      for (int k = 0; k < 4; k++)
         d[k*32 +: 32] = 32'(seed) * 32'h01010101 + 32'(k) * 32'h00100017 + 32'h5A000000;
      return d;
   endfunction

   task automatic send(input int blk, input int off, input int tid, input string rq);
      int h = -1;
      int fr = -1;
      bit exp_rdy;
      bit act_rdy;
      for (int e = 0; e < NE; e++) if (mvld[e] != 0 && mblk[e] == blk) h = e;
      for (int e = NE - 1; e >= 0; e--) if (mvld[e] == 0) fr = e;
      exp_rdy = (h >= 0) ? (mcnt[h] < NS) : (fr >= 0);
      @(negedge clk);
      req_valid = 1'b1;
      req_addr  = 12'((blk << 4) | off);
      req_tid   = 4'(tid);
      #1;
      act_rdy = req_ready;
      chk(act_rdy == exp_rdy, {rq, " req_ready"}, act_rdy, exp_rdy);
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      if (exp_rdy && h < 0) begin
         chk(fill_req_valid == 1'b1, {rq, " fill pulse"}, fill_req_valid, 1);
         chk(fill_req_id == 2'(fr), {rq, " fill id"}, fill_req_id, fr);
         chk(fill_req_blk == 8'(blk), "R1 fill block address", fill_req_blk, blk);
         mvld[fr] = 1; mblk[fr] = blk; mcnt[fr] = 1;
         mtid[fr][0] = tid; moff[fr][0] = off;
      end else begin
         chk(fill_req_valid == 1'b0, {rq, " no fill"}, fill_req_valid, 0);
         if (exp_rdy) begin
            mtid[h][mcnt[h]] = tid; moff[h][mcnt[h]] = off; mcnt[h]++;
         end
      end
   endtask

   task automatic respond(input int id, input logic [127:0] data, input string rq);
      @(negedge clk);
      rsp_valid = 1'b1;
      rsp_id    = 2'(id);
      rsp_data  = data;
      #1;
      chk(rsp_ready == 1'b1, "R7 rsp_ready idle", rsp_ready, 1);
      @(posedge clk);
      @(negedge clk);
      rsp_valid = 1'b0;
      if (mvld[id] != 0) begin
         for (int s = 0; s < mcnt[id]; s++) begin
            chk(cpl_valid == 1'b1, {rq, " cpl_valid"}, cpl_valid, 1);
            chk(cpl_tid == 4'(mtid[id][s]), {rq, " R5 cpl_tid order"}, cpl_tid, mtid[id][s]);
            chk(cpl_off == 4'(moff[id][s]), "R5 cpl_off", cpl_off, moff[id][s]);
            chk(cpl_word == data[(moff[id][s] / 4) * 32 +: 32], "R5 cpl_word",
                cpl_word, data[(moff[id][s] / 4) * 32 +: 32]);
            chk(rsp_ready == 1'b0, "R7 rsp_ready during playback", rsp_ready, 0);
            @(negedge clk);
         end
         chk(cpl_valid == 1'b0, "R5 playback length", cpl_valid, 0);
         mvld[id] = 0;
      end else begin
         chk(cpl_valid == 1'b0, "R8 no completion", cpl_valid, 0);
         chk(err_flag == 1'b1, "R8 err_flag set", err_flag, 1);
      end
   endtask

   initial begin
      for (int e = 0; e < NE; e++) begin mvld[e] = 0; mcnt[e] = 0; end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      chk(req_ready == 1'b1, "R9 req_ready", req_ready, 1);
      chk(rsp_ready == 1'b1, "R9 rsp_ready", rsp_ready, 1);
      chk(fill_req_valid == 1'b0, "R9 fill_req_valid", fill_req_valid, 0);
      chk(cpl_valid == 1'b0, "R9 cpl_valid", cpl_valid, 0);
      chk(err_flag == 1'b0, "R9 err_flag", err_flag, 0);

      send(8'h10, 4, 0, "R3");
      send(8'h23, 8, 1, "R3");
      send(8'h3a, 12, 2, "R3");
      send(8'h41, 0, 3, "R3");
      send(8'h23, 0, 5, "R2");
      send(8'h23, 4, 6, "R4 merge list full");
      send(8'h55, 0, 7, "R4 table full");
      respond(2, mk(2), "R6");
      send(8'h77, 12, 8, "R3 reuse lowest free");
      respond(1, mk(1), "R5");
      chk(err_flag == 1'b0, "R8 no error on live entry", err_flag, 0);
      respond(1, mk(9), "R8");
      send(8'h23, 8, 9, "R7 freed block reallocates");
      chk(err_flag == 1'b1, "R8 err_flag sticky", err_flag, 1);
      respond(3, mk(3), "R6");
      respond(0, mk(4), "R6");
      respond(2, mk(5), "R6");
      respond(1, mk(6), "R6");

      for (int k = 0; k < 16; k++) begin
         send(8'h80 + k, (k * 4) % 16, k, "R3 sweep");
         send(8'h80 + k, ((k + 1) * 4) % 16, (k + 3) % 16, "R2 sweep");
         send(8'h80 + k, 8, 15, "R4 sweep");
         if (k % 2 == 1) begin
            send(8'hC0 + k, (k * 4 + 8) % 16, 14, "R3 sweep second");
            respond(1, mk(40 + k), "R6 sweep");
         end
         respond(0, mk(20 + k), "R5 sweep");
      end

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule